// File: doc/BRIEF.md
# Four-Lane Saturating Byte ALU

This block splits two 32-bit words into four independent byte lanes and applies one lane operation chosen by a 7-bit opcode. The operations are signed and unsigned minimum and maximum, absolute value, negation, saturating addition and subtraction, and a per-lane shift whose signed 4-bit amount comes from the matching byte of the second operand. There are also bitwise AND, OR and XOR against an immediate byte. Arithmetic results are clipped to the signed or the unsigned byte range, and the opcode selects which. The shift result is never clipped.

Opcode bit 4 selects the unsigned variant. Opcode bit 5 replaces the second register operand with an 8-bit immediate that is copied into all four lanes. The caller extracts that immediate from the instruction word and presents it on its own port. Every recognised opcode drives the condition output low. Any other opcode is a no-op: the destination value presented on the first operand comes back unchanged, and the incoming condition value is passed through. Results are registered and appear one clock after the inputs.

Top module: `byte_sat_alu`

## Requirements
- R1: A clock edge with `rst_n` low clears `res_out` to 0 and `cond_out` to 0, whatever the other inputs are.
- R2: The outputs change only at the clock edge that follows the inputs. For every recognised opcode, `cond_out` is 0 after that edge, even when `cond_in` is 1.
- R3: Opcode 0x08 gives the signed minimum and 0x09 the signed maximum of each lane pair. Opcode 0x18 gives the unsigned minimum and 0x19 the unsigned maximum.
- R4: With opcode bit 5 set, the second operand of every lane is `imm_byte` and `src_b` has no effect. This applies, for example, to 0x28/0x29/0x38/0x39 for min/max and to 0x2c for add.
- R5: Opcode 0x0a gives the signed absolute value of each lane, with 0x80 mapped to 0x7f. Opcode 0x1a returns the lane unchanged. Opcodes 0x2a and 0x3a behave the same as 0x0a and 0x1a.
- R6: Opcode 0x0b negates each signed lane, with 0x80 mapped to 0x7f. Opcode 0x1b always gives 0. Opcodes 0x2b and 0x3b behave the same as 0x0b and 0x1b.
- R7: Opcodes 0x0c/0x2c add lanes with saturation to [-128, 127]. Opcodes 0x1c/0x3c add with saturation to [0, 255].
- R8: Opcodes 0x0d/0x2d subtract the second operand from the first with signed saturation. Opcodes 0x1d/0x3d do the same with unsigned saturation.
- R9: Opcodes 0x0e/0x2e shift each lane right arithmetically, and 0x1e/0x3e shift right logically. The amount is bits [3:0] of the matching second-operand byte, read as a two's-complement value from -8 to 7. A negative amount shifts left by its magnitude and discards the bits shifted out. The upper four bits of that byte have no effect, and the result is not clipped.
- R10: Opcodes 0x25, 0x26 and 0x27 compute the AND, OR and XOR of each lane with `imm_byte`.
- R11: Any opcode not listed in R3 to R10, including all opcodes with bit 6 set, gives `res_out` = `src_a` and `cond_out` = `cond_in` after the edge.
- R12: Lanes are independent: saturation or a carry in one lane never changes another lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 7 | Operation selector |
| imm_byte | input | 8 | Immediate byte, copied to all lanes when opcode bit 5 is set |
| src_a | input | 32 | First operand; also the value held on a no-op |
| src_b | input | 32 | Second register operand |
| cond_in | input | 1 | Incoming condition value, passed through on a no-op |
| res_out | output | 32 | Registered lane result |
| cond_out | output | 1 | Registered condition output |

## Verification
The bench builds the block with its defaults: four lanes of eight bits and a four-bit shift amount. This puts every clipping boundary (0x7f, 0x80, 0xff, 0x00) within reach of hand-written vectors. It also makes the whole shift range from -8 to 7 reachable, including -8, which clears a lane completely. Vectors place different edge bytes in neighbouring lanes so that saturation in one lane can be seen not to disturb the next. Aliases, immediate forms and no-op opcodes are checked against the register and condition values they must carry.

// File: rtl/byte_alu_pkg.sv
// Shared types for the saturating byte ALU.
// Assumes a 7-bit opcode: bit 6 set means no-op, bit 5 selects the immediate,
// bit 4 selects the unsigned variant, and bits 3:0 select the lane function.
package byte_alu_pkg;

    localparam int OPC_W = 7;

    typedef enum logic [3:0] {
        FN_NOP = 4'd0,
        FN_MIN = 4'd1,
        FN_MAX = 4'd2,
        FN_ABS = 4'd3,
        FN_NEG = 4'd4,
        FN_ADD = 4'd5,
        FN_SUB = 4'd6,
        FN_SHR = 4'd7,
        FN_AND = 4'd8,
        FN_OR  = 4'd9,
        FN_XOR = 4'd10
    } lane_fn_e;

    typedef struct packed {
        lane_fn_e fn;
        logic     is_uns;
        logic     use_imm;
        logic     active;
    } alu_ctrl_t;

endpackage

// File: rtl/byte_alu_decode.sv
// Opcode decoder: turns the 7-bit opcode into a lane function plus the
// signedness and immediate-select flags. Unlisted opcodes decode to FN_NOP
// with active low. Purely combinational.
module byte_alu_decode
    import byte_alu_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    output alu_ctrl_t        ctrl
);

    lane_fn_e fn_sel;

    // Pick the lane function from the opcode family nibble.
    always_comb begin
        fn_sel = FN_NOP;
        if (!op_code[6]) begin
            case (op_code[3:0])
                4'h8:    fn_sel = FN_MIN;
                4'h9:    fn_sel = FN_MAX;
                4'ha:    fn_sel = FN_ABS;
                4'hb:    fn_sel = FN_NEG;
                4'hc:    fn_sel = FN_ADD;
                4'hd:    fn_sel = FN_SUB;
                4'he:    fn_sel = FN_SHR;
                4'h5:    fn_sel = (op_code[5:4] == 2'b10) ? FN_AND : FN_NOP;
                4'h6:    fn_sel = (op_code[5:4] == 2'b10) ? FN_OR  : FN_NOP;
                4'h7:    fn_sel = (op_code[5:4] == 2'b10) ? FN_XOR : FN_NOP;
                default: fn_sel = FN_NOP;
            endcase
        end
    end

    // Pack the decoded fields for the datapath.
    always_comb begin
        ctrl.fn      = fn_sel;
        ctrl.is_uns  = op_code[4];
        ctrl.use_imm = op_code[5];
        ctrl.active  = (fn_sel != FN_NOP);
    end

endmodule

// File: rtl/byte_alu_opsel.sv
// Second-operand select: sends either the register word or the immediate
// byte, copied into every lane, to the lanes. Combinational.
module byte_alu_opsel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    use_imm,
    input  logic [LANE_W-1:0]       imm_byte,
    input  logic [LANES*LANE_W-1:0] reg_b,
    output logic [LANES*LANE_W-1:0] b_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_b
        // One lane's second operand: immediate copy or register byte.
        assign b_word[g*LANE_W +: LANE_W] = use_imm ? imm_byte : reg_b[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/byte_alu_lane.sv
// One byte lane. The operands are widened by two bits so that every sum,
// difference and negation is exact, and one clip step then maps the result
// to the signed or unsigned lane range. Shifts are not clipped.
// Assumes 2 <= SHAMT_W <= LANE_W.
module byte_alu_lane
    import byte_alu_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int SHAMT_W = 4
) (
    input  lane_fn_e          fn,
    input  logic              is_uns,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);

    localparam int W2 = LANE_W + 2;
    localparam logic signed [W2-1:0] U_HI = W2'((1 << LANE_W) - 1);
    localparam logic signed [W2-1:0] S_HI = W2'((1 << (LANE_W - 1)) - 1);
    localparam logic signed [W2-1:0] S_LO = ~S_HI;

    logic signed [W2-1:0]      xa, xb, sum_w, dif_w, neg_w, abs_w;
    logic                      a_lt_b;
    logic signed [SHAMT_W:0]   amt_x;
    logic [SHAMT_W:0]          left_n;
    logic [SHAMT_W-2:0]        right_n;
    logic [LANE_W-1:0]         shift_y;

    // Map an exact wide value onto the selected lane range.
    function automatic logic [LANE_W-1:0] clip(input logic signed [W2-1:0] v,
                                               input logic u);
        if (u) begin
            if (v[W2-1])      return '0;
            else if (v > U_HI) return '1;
            else              return v[LANE_W-1:0];
        end else begin
            if (v > S_HI)      return S_HI[LANE_W-1:0];
            else if (v < S_LO) return S_LO[LANE_W-1:0];
            else               return v[LANE_W-1:0];
        end
    endfunction

    // Widen both operands by sign or zero extension, then form the exact results.
    always_comb begin
        xa     = is_uns ? $signed({2'b00, a}) : $signed({{2{a[LANE_W-1]}}, a});
        xb     = is_uns ? $signed({2'b00, b}) : $signed({{2{b[LANE_W-1]}}, b});
        sum_w  = xa + xb;
        dif_w  = xa - xb;
        neg_w  = -xa;
        abs_w  = xa[W2-1] ? neg_w : xa;
        a_lt_b = (xa < xb);
    end

    // Shift by the signed amount in the low bits of b; a negative amount shifts left.
    always_comb begin
        amt_x   = $signed({b[SHAMT_W-1], b[SHAMT_W-1:0]});
        left_n  = -amt_x;
        right_n = b[SHAMT_W-2:0];
        if (amt_x[SHAMT_W])
            shift_y = a << left_n;
        else if (is_uns)
            shift_y = a >> right_n;
        else
            shift_y = $signed(a) >>> right_n;
    end

    // Select the lane result for the decoded function.
    always_comb begin
        case (fn)
            FN_MIN:  y = a_lt_b ? a : b;
            FN_MAX:  y = a_lt_b ? b : a;
            FN_ABS:  y = clip(abs_w, is_uns);
            FN_NEG:  y = clip(neg_w, is_uns);
            FN_ADD:  y = clip(sum_w, is_uns);
            FN_SUB:  y = clip(dif_w, is_uns);
            FN_SHR:  y = shift_y;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end

    // The signed absolute value must never come out negative.
    always_comb begin
        if (fn == FN_ABS && !is_uns) begin
            assert_abs_nonneg_R5: assert (!y[LANE_W-1]);
        end
    end

endmodule

// File: rtl/byte_sat_alu.sv
// Top of the saturating byte ALU: decoder, operand select, LANES lane
// instances and one output register stage. Results appear one clock after
// the inputs. Recognised opcodes clear the condition output; other opcodes
// return src_a and pass cond_in through. Reset is synchronous and active low.
module byte_sat_alu
    import byte_alu_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    parameter int SHAMT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OPC_W-1:0]        op_code,
    input  logic [LANE_W-1:0]       imm_byte,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic                    cond_in,
    output logic [LANES*LANE_W-1:0] res_out,
    output logic                    cond_out
);

    localparam int WORD_W = LANES * LANE_W;

    alu_ctrl_t          dec_ctrl;
    logic [WORD_W-1:0]  b_word;
    logic [WORD_W-1:0]  lane_word;
    logic [WORD_W-1:0]  res_q;
    logic               cond_q;

    byte_alu_decode u_decode (
        .op_code (op_code),
        .ctrl    (dec_ctrl)
    );

    byte_alu_opsel #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_opsel (
        .use_imm  (dec_ctrl.use_imm),
        .imm_byte (imm_byte),
        .reg_b    (src_b),
        .b_word   (b_word)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;

        byte_alu_lane #(
            .LANE_W  (LANE_W),
            .SHAMT_W (SHAMT_W)
        ) u_lane (
            .fn     (dec_ctrl.fn),
            .is_uns (dec_ctrl.is_uns),
            .a      (src_a[LO +: LANE_W]),
            .b      (b_word[LO +: LANE_W]),
            .y      (lane_word[LO +: LANE_W])
        );

        // A signed minimum never exceeds the lane's first operand.
        assert_smin_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_ctrl.fn == FN_MIN && !dec_ctrl.is_uns) |=>
            ($signed(res_out[LO +: LANE_W]) <= $signed($past(src_a[LO +: LANE_W]))));

        // An unsigned maximum is never below the lane's first operand.
        assert_umax_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_ctrl.fn == FN_MAX && dec_ctrl.is_uns) |=>
            (res_out[LO +: LANE_W] >= $past(src_a[LO +: LANE_W])));

        // Unsigned negation always yields zero.
        assert_uneg_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_ctrl.fn == FN_NEG && dec_ctrl.is_uns) |=>
            (res_out[LO +: LANE_W] == '0));

        // A saturating unsigned add never drops below its first operand.
        assert_uadd_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_ctrl.fn == FN_ADD && dec_ctrl.is_uns) |=>
            (res_out[LO +: LANE_W] >= $past(src_a[LO +: LANE_W])));

        // A saturating unsigned subtract never rises above its first operand.
        assert_usub_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_ctrl.fn == FN_SUB && dec_ctrl.is_uns) |=>
            (res_out[LO +: LANE_W] <= $past(src_a[LO +: LANE_W])));
    end

    // Output register: the lane result or the held value, plus the condition bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            cond_q <= 1'b0;
        end else begin
            res_q  <= dec_ctrl.active ? lane_word : src_a;
            cond_q <= dec_ctrl.active ? 1'b0 : cond_in;
        end
    end

    assign res_out  = res_q;
    assign cond_out = cond_q;

    // Reset clears both outputs at the next edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (res_out == '0 && !cond_out));

    // Recognised opcodes leave the condition output low.
    assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ctrl.active |=> !cond_out);

    // A no-op returns the first operand and the incoming condition value.
    assert_nop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_ctrl.active |=> (res_out == $past(src_a) && cond_out == $past(cond_in)));

endmodule

// File: tb/byte_sat_alu_test.sv
// Bench for byte_sat_alu: a vector table walked by one loop, then directed
// tests for reset, latency, immediate select and lane independence.
module byte_sat_alu_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    // Vector fields: op[112:106] imm[105:98] a[97:66] b[65:34] cin[33] exp[32:1] ef[0]
    localparam logic [112:0] VEC [NV] = '{
        {7'h08, 8'h00, 32'h7F8001FF, 32'h807FFF01, 1'b1, 32'h8080FFFF, 1'b0},
        {7'h18, 8'h00, 32'h7F8001FF, 32'h807FFF01, 1'b1, 32'h7F7F0101, 1'b0},
        {7'h09, 8'h00, 32'h7F8001FF, 32'h807FFF01, 1'b1, 32'h7F7F0101, 1'b0},
        {7'h19, 8'h00, 32'h7F8001FF, 32'h807FFF01, 1'b1, 32'h8080FFFF, 1'b0},
        {7'h28, 8'h10, 32'h0520F010, 32'h00000000, 1'b1, 32'h0510F010, 1'b0},
        {7'h39, 8'h80, 32'h0590F07F, 32'h00000000, 1'b1, 32'h8090F080, 1'b0},
        {7'h0A, 8'h00, 32'h80FF7F00, 32'h12345678, 1'b1, 32'h7F017F00, 1'b0},
        {7'h1A, 8'h00, 32'h80FF7F00, 32'h12345678, 1'b1, 32'h80FF7F00, 1'b0},
        {7'h2A, 8'h00, 32'h810005FB, 32'h00000000, 1'b1, 32'h7F000505, 1'b0},
        {7'h0B, 8'h00, 32'h80FF0100, 32'h00000000, 1'b1, 32'h7F01FF00, 1'b0},
        {7'h1B, 8'h00, 32'h80FF0100, 32'h00000000, 1'b1, 32'h00000000, 1'b0},
        {7'h3B, 8'h00, 32'h12345678, 32'h00000000, 1'b1, 32'h00000000, 1'b0},
        {7'h0C, 8'h00, 32'h70907FFF, 32'h20F00101, 1'b1, 32'h7F807F00, 1'b0},
        {7'h1C, 8'h00, 32'h70907FFF, 32'h20F00101, 1'b1, 32'h90FF80FF, 1'b0},
        {7'h2C, 8'h7F, 32'h018000FF, 32'h00000000, 1'b1, 32'h7FFF7F7E, 1'b0},
        {7'h0D, 8'h00, 32'h807F1000, 32'h01FF2080, 1'b1, 32'h807FF07F, 1'b0},
        {7'h1D, 8'h00, 32'h807F1000, 32'h01FF2080, 1'b1, 32'h7F000000, 1'b0},
        {7'h0E, 8'h00, 32'h80801340, 32'hF751AC38, 1'b1, 32'hFFC03000, 1'b0},
        {7'h1E, 8'h00, 32'h80801340, 32'hF751AC38, 1'b1, 32'h01403000, 1'b0},
        {7'h3E, 8'h0F, 32'h010281FF, 32'h00000000, 1'b1, 32'h020402FE, 1'b0},
        {7'h25, 8'h0F, 32'h12345678, 32'hFFFFFFFF, 1'b1, 32'h02040608, 1'b0},
        {7'h26, 8'hF0, 32'h12345678, 32'h00000000, 1'b1, 32'hF2F4F6F8, 1'b0},
        {7'h27, 8'hFF, 32'h12345678, 32'h00000000, 1'b1, 32'hEDCBA987, 1'b0},
        {7'h4F, 8'h00, 32'hDEADBEEF, 32'h00000000, 1'b1, 32'hDEADBEEF, 1'b1},
        {7'h35, 8'h00, 32'hCAFEF00D, 32'h11111111, 1'b0, 32'hCAFEF00D, 1'b0},
        {7'h00, 8'hFF, 32'h01020304, 32'hFFFFFFFF, 1'b1, 32'h01020304, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  op_code = 7'h00;
    logic [7:0]  imm_byte = 8'h00;
    logic [31:0] src_a = 32'hFFFFFFFF;
    logic [31:0] src_b = 32'h0;
    logic        cond_in = 1'b1;
    logic [31:0] res_out;
    logic        cond_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    byte_sat_alu uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_code  (op_code),
        .imm_byte (imm_byte),
        .src_a    (src_a),
        .src_b    (src_b),
        .cond_in  (cond_in),
        .res_out  (res_out),
        .cond_out (cond_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Requirement tag that covers an opcode's result.
    function automatic string tag_of(input logic [6:0] op);
        if (op[6]) return "R11";
        case (op[3:0])
            4'h8, 4'h9: return "R3";
            4'ha:       return "R5";
            4'hb:       return "R6";
            4'hc:       return "R7";
            4'hd:       return "R8";
            4'he:       return "R9";
            4'h5, 4'h6, 4'h7: return (op[5:4] == 2'b10) ? "R10" : "R11";
            default:    return "R11";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s res_out actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic check1(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s cond_out actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [6:0] op, input logic [7:0] imm,
                         input logic [31:0] a, input logic [31:0] b, input logic cin);
        op_code  = op;
        imm_byte = imm;
        src_a    = a;
        src_b    = b;
        cond_in  = cin;
    endtask

    initial begin
        logic [31:0] prev;
        // R1: reset clears outputs although a no-op would pass ones through.
        repeat (2) @(negedge clk);
        check32("R1", res_out, 32'h0);
        check1("R1", cond_out, 1'b0);
        rst_n = 1'b1;

        // Table walk; flag expectation is R2 for decoded ops and R11 for no-ops.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][112:106], VEC[i][105:98], VEC[i][97:66], VEC[i][65:34], VEC[i][33]);
            @(negedge clk);
            check32(tag_of(VEC[i][112:106]), res_out, VEC[i][32:1]);
            check1(VEC[i][0] ? "R11" : "R2", cond_out, VEC[i][0]);
        end

        // R2: output holds until the edge after the inputs change.
        prev = res_out;
        drive(7'h1C, 8'h00, 32'h01010101, 32'h01010101, 1'b1);
        #1;
        check32("R2", res_out, prev);
        @(negedge clk);
        check32("R2", res_out, 32'h02020202);

        // R4: register form uses src_b, immediate form ignores it.
        drive(7'h0C, 8'h05, 32'h10101010, 32'h00000000, 1'b0);
        @(negedge clk);
        check32("R4", res_out, 32'h10101010);
        drive(7'h2C, 8'h05, 32'h10101010, 32'h7F7F7F7F, 1'b0);
        @(negedge clk);
        check32("R4", res_out, 32'h15151515);

        // R12: saturation or carry in one lane leaves its neighbours alone.
        drive(7'h1C, 8'h00, 32'h000000FF, 32'h00000001, 1'b0);
        @(negedge clk);
        check32("R12", res_out, 32'h000000FF);
        drive(7'h0C, 8'h00, 32'h007F0000, 32'h00010000, 1'b0);
        @(negedge clk);
        check32("R12", res_out, 32'h007F0000);

        // R9: the upper nibble of the amount byte has no effect.
        drive(7'h1E, 8'h00, 32'h80808080, 32'h01112131, 1'b0);
        @(negedge clk);
        check32("R9", res_out, 32'h40404040);

        // R1: reset in mid-run overrides a no-op carrying ones.
        drive(7'h4F, 8'h00, 32'hAAAAAAAA, 32'h0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check32("R1", res_out, 32'h0);
        check1("R1", cond_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R11", res_out, 32'hAAAAAAAA);
        check1("R11", cond_out, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule